// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit

This block adds or subtracts two binary floating-point numbers whose exponent and fraction widths are set by parameters. Each operand is packed as a sign bit, a biased exponent field and a fraction field. The leading mantissa bit is implied and not stored. The unit handles normal numbers, subnormal numbers (gradual underflow), signed zeros, infinities, and quiet and signaling NaNs. Four rounding directions are selectable on every operation.

Internally the smaller operand is aligned to the larger one. The mantissa path is three bits wider than the stored mantissa: a guard bit, a round bit and a sticky bit. The sticky bit collects every bit shifted out below the round bit. After the add or subtract, the sum is renormalized. A left shift uses a leading-zero count and never takes the exponent below the subnormal threshold. A carry out takes a one-place right shift instead. The sum is then rounded and packed.

The result and four exception flags (invalid, overflow, underflow, inexact) are captured in one register stage. A new operation can be issued on every clock.

Top module: `fp_addsub`

## Requirements
- R1: While `rst` is high at a rising edge, the result and all four flags become zero on that edge.
- R2: For finite operands with `rnd_mode` = 0, the result is the exact sum rounded to the nearest representable value, with ties going to the even mantissa. The operand value is (-1)^s x 1.f x 2^(e-bias) for a nonzero exponent field e, and (-1)^s x 0.f x 2^(1-bias) for e = 0, where bias = 2^(EXP_W-1)-1.
- R3: With `op_sub` = 1 the unit returns a - b, implemented by inverting the sign of b. With `op_sub` = 0 it returns a + b.
- R4: `rnd_mode` encodings: 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R5: Results below the smallest normal magnitude are delivered as subnormals (exponent field 0) and are never flushed to zero. The underflow flag is set exactly when the result is a nonzero subnormal.
- R6: If the rounded magnitude exceeds the largest finite value, the overflow and inexact flags are set. The result is infinity when the rounding direction moves away from zero (nearest-even, upward for positive results, downward for negative results). Otherwise it is the largest finite value with the sign of the result.
- R7: Any NaN operand yields the canonical quiet NaN: sign 0, exponent field all ones, fraction MSB 1, other fraction bits 0. A NaN whose fraction MSB is 0 is signaling and sets invalid. Quiet NaN inputs alone raise no flag.
- R8: Infinity combined with a finite value returns that infinity with its effective sign and no flag. Infinities of opposite effective sign give the canonical NaN and set invalid.
- R9: An exact zero sum of operands with opposite effective signs is +0, or -0 under rounding mode 3. Two zeros of the same effective sign keep that sign.
- R10: The inexact flag is set whenever the delivered result differs from the exact sum.
- R11: In the format with EXP_W = 3 and FRAC_W = 2, 0_100_00 minus 0_011_11 returns exactly 0_001_00 with no flags. This result depends on the guard bit kept through alignment.
- R12: Operands and controls sampled at one rising edge determine the result and flags visible after that edge. Outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | EXP_W+FRAC_W+1 | First operand {sign, exponent, fraction} |
| op_b | input | EXP_W+FRAC_W+1 | Second operand {sign, exponent, fraction} |
| op_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| rnd_mode | input | 2 | Rounding direction, encoded as in R4 |
| result | output | EXP_W+FRAC_W+1 | Registered rounded result |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Rounded result exceeded the finite range |
| flag_underflow | output | 1 | Result is a nonzero subnormal |
| flag_inexact | output | 1 | Result differs from the exact sum |

## Verification
The hardest case to reach is massive cancellation. Two operands whose exponents differ by at most one must leave bits in the guard position and force a long left shift, and the shift must stop at the subnormal boundary. Uniform random operands almost never line up this way. The stimulus therefore derives the second operand from the first, flipping only low fraction bits and keeping the exponent nearby. A second instance in a 6-bit format is swept over every operand pair, operation and rounding mode. That sweep covers every alignment distance, carry, tie and renormalization case against a reference that computes exact integer sums.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } fpa_flags_t;

    // Decide whether the truncated mantissa must be bumped by one ulp.
    function automatic logic rnd_increment(rmode_e m, logic sign, logic lsb,
                                           logic rbit, logic sticky);
        case (m)
            RM_NEAR_EVEN: return rbit & (sticky | lsb);
            RM_TO_ZERO:   return 1'b0;
            RM_UP:        return ~sign & (rbit | sticky);
            default:      return sign & (rbit | sticky);
        endcase
    endfunction

    // On overflow: saturate to infinity or to the largest finite value.
    function automatic logic ovf_to_inf(rmode_e m, logic sign);
        case (m)
            RM_NEAR_EVEN: return 1'b1;
            RM_TO_ZERO:   return 1'b0;
            RM_UP:        return ~sign;
            default:      return sign;
        endcase
    endfunction

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_eff,
    output logic [FRAC_W:0]       mant,
    output logic                  is_inf,
    output logic                  is_nan,
    output logic                  is_snan
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac;
    logic              exp_zero;
    logic              exp_ones;

    always_comb begin
        sign     = op[EXP_W+FRAC_W];
        exp_f    = op[FRAC_W +: EXP_W];
        frac     = op[FRAC_W-1:0];
        exp_zero = (exp_f == '0);
        exp_ones = &exp_f;
        // Subnormals share the scale of exponent 1 with no hidden bit.
        exp_eff  = exp_zero ? EXP_W'(1) : exp_f;
        mant     = {~exp_zero, frac};
        is_inf   = exp_ones & (frac == '0);
        is_nan   = exp_ones & (frac != '0);
        is_snan  = is_nan & ~frac[FRAC_W-1];
    end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10
) (
    input  logic [EXP_W+FRAC_W-1:0] a_mag,
    input  logic [EXP_W+FRAC_W-1:0] b_mag,
    input  logic [EXP_W-1:0]        a_exp,
    input  logic [EXP_W-1:0]        b_exp,
    input  logic [FRAC_W:0]         a_mant,
    input  logic [FRAC_W:0]         b_mant,
    input  logic                    a_sign,
    input  logic                    b_sign,
    input  logic                    eff_sub,
    output logic [FRAC_W+4:0]       sum,
    output logic [EXP_W-1:0]        big_exp,
    output logic                    big_sign
);
    localparam int MW  = FRAC_W + 1;
    localparam int PW  = MW + 3;
    localparam int XW  = 2 * MW + 3;
    localparam int SHW = $clog2(MW + 4);

    logic             swap;
    logic [MW-1:0]    big_m, sml_m;
    logic [EXP_W-1:0] sml_exp, diff;
    logic [SHW-1:0]   shamt;
    logic [XW-1:0]    wide;
    logic [PW-1:0]    big_p, sml_p;

    always_comb begin
        swap     = (b_mag > a_mag);
        big_m    = swap ? b_mant : a_mant;
        sml_m    = swap ? a_mant : b_mant;
        big_exp  = swap ? b_exp  : a_exp;
        sml_exp  = swap ? a_exp  : b_exp;
        big_sign = swap ? b_sign : a_sign;
        diff     = big_exp - sml_exp;
        // Past MW+3 places every bit lands in the sticky region anyway.
        shamt    = (int'(diff) > MW + 3) ? SHW'(MW + 3) : SHW'(diff);
        wide     = {sml_m, {(MW + 3){1'b0}}} >> shamt;
        sml_p    = {wide[XW-1 -: MW+2], |wide[MW:0]};
        big_p    = {big_m, 3'b000};
        if (eff_sub)
            sum = {1'b0, big_p} - {1'b0, sml_p};
        else
            sum = {1'b0, big_p} + {1'b0, sml_p};
    end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
    parameter int W = 14
) (
    input  logic [W-1:0]           v,
    output logic [$clog2(W+1)-1:0] cnt
);
    localparam int CW = $clog2(W + 1);
    logic found;

    always_comb begin
        cnt   = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && v[i]) begin
                cnt   = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpa_normround.sv
module fpa_normround
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10
) (
    input  logic [FRAC_W+4:0]     sum,
    input  logic [EXP_W-1:0]      big_exp,
    input  logic                  sign,
    input  logic                  zero_sign,
    input  rmode_e                rm,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  ovf,
    output logic                  unf,
    output logic                  inx
);
    localparam int MW  = FRAC_W + 1;
    localparam int MW1 = MW + 1;
    localparam int PW  = MW + 3;
    localparam int LZW = $clog2(PW + 1);
    localparam int EW1 = EXP_W + 1;
    localparam logic [EW1-1:0] EXP_TOP = EW1'((1 << EXP_W) - 1);

    logic [LZW-1:0]    lz;
    logic              sum_zero;
    logic [PW-1:0]     norm;
    logic [EW1-1:0]    exp_n, exp_r;
    logic [MW-1:0]     mant;
    logic              g_bit, st_bit, inc;
    logic [MW:0]       mr;
    logic [FRAC_W-1:0] frac_r;
    int                lim, sh;

    fpa_lzc #(.W(PW)) u_lzc (
        .v   (sum[PW-1:0]),
        .cnt (lz)
    );

    always_comb begin
        sum_zero = (sum == '0);
        lim      = int'(big_exp) - 1;
        sh       = 0;
        if (sum[PW]) begin
            // Carry out: one place right, the dropped bit joins sticky.
            norm  = {sum[PW:2], sum[1] | sum[0]};
            exp_n = EW1'({1'b0, big_exp}) + EW1'(1);
        end else begin
            // Left shift bounded so the exponent never drops below 1.
            sh    = (int'(lz) < lim) ? int'(lz) : lim;
            norm  = sum[PW-1:0] << sh;
            exp_n = EW1'({1'b0, big_exp}) - EW1'(sh);
        end
        mant   = norm[PW-1:3];
        g_bit  = norm[2];
        st_bit = |norm[1:0];
        inc    = rnd_increment(rm, sign, mant[0], g_bit, st_bit);
        mr     = {1'b0, mant} + MW1'(inc);
        if (mr[MW]) begin
            exp_r  = exp_n + EW1'(1);
            frac_r = '0;
        end else begin
            exp_r  = mr[MW-1] ? exp_n : '0;
            frac_r = mr[FRAC_W-1:0];
        end

        ovf = 1'b0;
        unf = 1'b0;
        inx = 1'b0;
        if (sum_zero) begin
            res = {zero_sign, {(EXP_W + FRAC_W){1'b0}}};
        end else if (exp_r >= EXP_TOP) begin
            ovf = 1'b1;
            inx = 1'b1;
            if (ovf_to_inf(rm, sign))
                res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            else
                res = {sign, {(EXP_W - 1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
            res = {sign, exp_r[EXP_W-1:0], frac_r};
            inx = g_bit | st_bit;
            unf = ~norm[PW-1];
        end
    end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  op_sub,
    input  logic [1:0]            rnd_mode,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  flag_invalid,
    output logic                  flag_overflow,
    output logic                  flag_underflow,
    output logic                  flag_inexact
);
    localparam int OPW = EXP_W + FRAC_W + 1;
    localparam logic [OPW-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};
    localparam logic [OPW-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [OPW-1:0]    ops    [2];
    logic              u_sign [2];
    logic [EXP_W-1:0]  u_exp  [2];
    logic [FRAC_W:0]   u_mant [2];
    logic              u_inf  [2];
    logic              u_nan  [2];
    logic              u_snan [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .op      (ops[i]),
            .sign    (u_sign[i]),
            .exp_eff (u_exp[i]),
            .mant    (u_mant[i]),
            .is_inf  (u_inf[i]),
            .is_nan  (u_nan[i]),
            .is_snan (u_snan[i])
        );
    end

    rmode_e rm;
    logic   a_s, b_s, eff_sub, zero_sign;

    always_comb begin
        rm        = rmode_e'(rnd_mode);
        a_s       = u_sign[0];
        b_s       = u_sign[1] ^ op_sub;
        eff_sub   = a_s ^ b_s;
        zero_sign = (a_s & b_s) | (eff_sub & (rm == RM_DOWN));
    end

    logic [FRAC_W+4:0] sum;
    logic [EXP_W-1:0]  big_exp;
    logic              big_sign;

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .a_mag    (op_a[OPW-2:0]),
        .b_mag    (op_b[OPW-2:0]),
        .a_exp    (u_exp[0]),
        .b_exp    (u_exp[1]),
        .a_mant   (u_mant[0]),
        .b_mant   (u_mant[1]),
        .a_sign   (a_s),
        .b_sign   (b_s),
        .eff_sub  (eff_sub),
        .sum      (sum),
        .big_exp  (big_exp),
        .big_sign (big_sign)
    );

    logic [OPW-1:0] path_res;
    logic           path_ovf, path_unf, path_inx;

    fpa_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_normround (
        .sum       (sum),
        .big_exp   (big_exp),
        .sign      (big_sign),
        .zero_sign (zero_sign),
        .rm        (rm),
        .res       (path_res),
        .ovf       (path_ovf),
        .unf       (path_unf),
        .inx       (path_inx)
    );

    logic [OPW-1:0] res_d, res_q;
    fpa_flags_t     flg_d, flg_q;

    always_comb begin
        res_d = path_res;
        flg_d = '0;
        flg_d.overflow  = path_ovf;
        flg_d.underflow = path_unf;
        flg_d.inexact   = path_inx;
        if (u_nan[0] | u_nan[1]) begin
            res_d = QNAN;
            flg_d = '0;
            flg_d.invalid = u_snan[0] | u_snan[1];
        end else if (u_inf[0] & u_inf[1] & eff_sub) begin
            res_d = QNAN;
            flg_d = '0;
            flg_d.invalid = 1'b1;
        end else if (u_inf[0]) begin
            res_d = {a_s, INF_MAG};
            flg_d = '0;
        end else if (u_inf[1]) begin
            res_d = {b_s, INF_MAG};
            flg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= '0;
        end else begin
            res_q <= res_d;
            flg_q <= flg_d;
        end
    end

    assign result         = res_q;
    assign flag_invalid   = flg_q.invalid;
    assign flag_overflow  = flg_q.overflow;
    assign flag_underflow = flg_q.underflow;
    assign flag_inexact   = flg_q.inexact;

    // R6: an overflowed result is never exact
    a_r6_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
        flag_overflow |-> flag_inexact);

    // R5: underflow only accompanies a nonzero subnormal encoding
    a_r5_unf_subnormal: assert property (@(posedge clk) disable iff (rst)
        flag_underflow |-> (result[FRAC_W +: EXP_W] == '0 &&
                            result[FRAC_W-1:0] != '0 && !flag_overflow));

    // R7: any NaN on the output is the canonical quiet NaN
    a_r7_nan_canonical: assert property (@(posedge clk) disable iff (rst)
        (&result[FRAC_W +: EXP_W] && result[FRAC_W-1:0] != '0) |-> result == QNAN);

    // R7: a NaN operand produces the canonical NaN one edge later
    a_r7_nan_propagates: assert property (@(posedge clk) disable iff (rst)
        (u_nan[0] | u_nan[1]) |=> result == QNAN);

    // R8: invalid is only ever reported with a NaN result
    a_r8_invalid_nan: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> result == QNAN);

    // R12: outputs follow inputs with one register stage
    a_r12_one_stage: assert property (@(posedge clk) disable iff (rst)
        (u_inf[0] && !u_nan[1] && !u_inf[1]) |=> result == {$past(a_s), INF_MAG});
endmodule

// File: tb/sim_fp_addsub.sv
module sim_fp_addsub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a0 = 16'h3C00, b0 = 16'h3C00;
    logic [5:0]  a1 = 6'd0, b1 = 6'd0;
    logic        op_sub = 1'b0;
    logic [1:0]  rnd = 2'd0;

    logic [15:0] r0;
    logic [5:0]  r1;
    logic        inv0, ovf0, unf0, inx0;
    logic        inv1, ovf1, unf1, inx1;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fp_addsub #(.EXP_W(5), .FRAC_W(10)) u0 (
        .clk(clk), .rst(rst), .op_a(a0), .op_b(b0), .op_sub(op_sub),
        .rnd_mode(rnd), .result(r0), .flag_invalid(inv0),
        .flag_overflow(ovf0), .flag_underflow(unf0), .flag_inexact(inx0));

    fp_addsub #(.EXP_W(3), .FRAC_W(2)) u1 (
        .clk(clk), .rst(rst), .op_a(a1), .op_b(b1), .op_sub(op_sub),
        .rnd_mode(rnd), .result(r1), .flag_invalid(inv1),
        .flag_overflow(ovf1), .flag_underflow(unf1), .flag_inexact(inx1));

    // Exact reference: operands scaled to integer multiples of the smallest subnormal.
    // Returns {invalid, overflow, underflow, inexact, result[15:0]}.
    function automatic logic [19:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                           input logic sub, input logic [1:0] rm,
                                           input int E, input int F);
        longint emax, fmask, ea, eb, fa, fb, va, vb, v, mag, keep, rem, half, qnan, res, fld;
        logic sa, sb, na, nb, s, inv, ovf, unf, inx, inc, toinf;
        int p, shf;
        emax  = (longint'(1) << E) - 1;
        fmask = (longint'(1) << F) - 1;
        sa = a[E+F];
        sb = b[E+F] ^ sub;
        ea = (longint'(a) >> F) & emax;
        eb = (longint'(b) >> F) & emax;
        fa = longint'(a) & fmask;
        fb = longint'(b) & fmask;
        qnan = (emax << F) | (longint'(1) << (F - 1));
        inv = 0; ovf = 0; unf = 0; inx = 0; res = 0;
        na = (ea == emax) && (fa != 0);
        nb = (eb == emax) && (fb != 0);
        if (na || nb) begin
            res = qnan;
            inv = (na && ((fa >> (F - 1)) & 1) == 0) || (nb && ((fb >> (F - 1)) & 1) == 0);
        end else if (ea == emax && eb == emax) begin
            if (sa != sb) begin res = qnan; inv = 1; end
            else res = (longint'(sa) << (E + F)) | (emax << F);
        end else if (ea == emax) begin
            res = (longint'(sa) << (E + F)) | (emax << F);
        end else if (eb == emax) begin
            res = (longint'(sb) << (E + F)) | (emax << F);
        end else begin
            va = (ea != 0) ? ((fa | (longint'(1) << F)) << (ea - 1)) : fa;
            vb = (eb != 0) ? ((fb | (longint'(1) << F)) << (eb - 1)) : fb;
            v  = (sa ? -va : va) + (sb ? -vb : vb);
            if (v == 0) begin
                s = (sa && sb) || ((sa != sb) && rm == 2'd3);
                res = longint'(s) << (E + F);
            end else begin
                s   = (v < 0);
                mag = s ? -v : v;
                if (mag < (longint'(1) << F)) begin
                    res = (longint'(s) << (E + F)) | mag;
                    unf = 1;
                end else begin
                    p = 0;
                    for (int i = 0; i < 62; i++) if (((mag >> i) & 1) != 0) p = i;
                    shf  = p - F;
                    keep = mag >> shf;
                    rem  = mag - (keep << shf);
                    half = (shf > 0) ? (longint'(1) << (shf - 1)) : 0;
                    inx  = (rem != 0);
                    case (rm)
                        2'd0:    inc = (rem > half) || (rem == half && rem != 0 && (keep & 1) != 0);
                        2'd1:    inc = 0;
                        2'd2:    inc = !s && rem != 0;
                        default: inc = s && rem != 0;
                    endcase
                    keep = keep + longint'(inc);
                    if (keep == (longint'(1) << (F + 1))) begin
                        keep = keep >> 1;
                        shf  = shf + 1;
                    end
                    fld = longint'(shf) + 1;
                    if (fld >= emax) begin
                        ovf = 1; inx = 1;
                        toinf = (rm == 2'd0) || (rm == 2'd2 && !s) || (rm == 2'd3 && s);
                        if (toinf) res = (longint'(s) << (E + F)) | (emax << F);
                        else res = (longint'(s) << (E + F)) | ((emax - 1) << F) | fmask;
                    end else begin
                        res = (longint'(s) << (E + F)) | (fld << F) | (keep & fmask);
                    end
                end
            end
        end
        return {inv, ovf, unf, inx, res[15:0]};
    endfunction

    function automatic string tag_of(input logic [19:0] e, input logic sub,
                                     input logic [1:0] rm, input int E, input int F);
        longint emax, ex, fr;
        emax = (longint'(1) << E) - 1;
        ex = (longint'(e[15:0]) >> F) & emax;
        fr = longint'(e[15:0]) & ((longint'(1) << F) - 1);
        if (ex == emax && fr != 0) return "R7";
        if (e[18]) return "R6";
        if (ex == emax) return "R8";
        if (e[17]) return "R5";
        if (ex == 0 && fr == 0) return "R9";
        if (sub) return "R3";
        if (rm != 2'd0) return "R4";
        if (e[16]) return "R10";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp,
                         input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive the half-precision instance at a falling edge, check at the next one.
    task automatic do16(input logic [15:0] a, input logic [15:0] b, input logic sub,
                        input logic [1:0] rm, input string tag);
        logic [19:0] e;
        string t;
        a0 = a; b0 = b; op_sub = sub; rnd = rm;
        @(negedge clk);
        e = ref_add(a, b, sub, rm, 5, 10);
        t = (tag == "") ? tag_of(e, sub, rm, 5, 10) : tag;
        check(t, {inv0, ovf0, unf0, inx0, r0}, e, "half");
    endtask

    task automatic lit16(input logic [15:0] a, input logic [15:0] b, input logic sub,
                         input logic [1:0] rm, input logic [15:0] xr, input logic [3:0] xf,
                         input string tag);
        a0 = a; b0 = b; op_sub = sub; rnd = rm;
        @(negedge clk);
        check(tag, {inv0, ovf0, unf0, inx0, r0}, {xf, xr}, "directed");
    endtask

    task automatic do6(input logic [5:0] a, input logic [5:0] b, input logic sub,
                       input logic [1:0] rm);
        logic [19:0] e;
        a1 = a; b1 = b; op_sub = sub; rnd = rm;
        @(negedge clk);
        e = ref_add({10'd0, a}, {10'd0, b}, sub, rm, 3, 2);
        check(tag_of(e, sub, rm, 3, 2), {inv1, ovf1, unf1, inx1, 10'd0, r1}, {e[19:16], 10'd0, e[5:0]}, "tiny");
    endtask

    function automatic logic [15:0] rand_op();
        logic [15:0] x;
        int k;
        x = 16'($urandom);
        k = int'($urandom % 8);
        case (k)
            3: x[14:10] = ($urandom % 2 == 0) ? 5'd0 : 5'd31;
            4: x[14:10] = 5'd28 + 5'($urandom % 3);
            5: x[14:10] = 5'($urandom % 3);
            6: if ($urandom % 2 == 0) x[9:0] = 10'd0;
            default: ;
        endcase
        return x;
    endfunction

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] ra, rb;
        void'($urandom(32'd20240611));
        // R1: outputs cleared by reset even with live operands
        repeat (3) @(negedge clk);
        check("R1", {inv0, ovf0, unf0, inx0, r0}, 20'd0, "reset");
        check("R1", {inv1, ovf1, unf1, inx1, 10'd0, r1}, 20'd0, "reset tiny");
        rst = 1'b0;
        // R12: output holds until the next rising edge, then shows the new sum
        a0 = 16'h3C00; b0 = 16'h3C00;
        #5;
        check("R12", {16'd0, r0}, 20'd0, "before edge");
        @(negedge clk);
        check("R12", {16'd0, r0}, {16'd0, 16'h4000}, "after edge");

        lit16(16'h3C00, 16'h3C00, 1'b0, 2'd0, 16'h4000, 4'b0000, "R2");
        lit16(16'h4200, 16'h3C00, 1'b1, 2'd0, 16'h4000, 4'b0000, "R3");
        lit16(16'h4200, 16'h3C00, 1'b0, 2'd0, 16'h4400, 4'b0000, "R3");
        lit16(16'h3C00, 16'h1000, 1'b0, 2'd0, 16'h3C00, 4'b0001, "R4");
        lit16(16'h3C00, 16'h1000, 1'b0, 2'd2, 16'h3C01, 4'b0001, "R4");
        lit16(16'hBC00, 16'h1000, 1'b1, 2'd3, 16'hBC01, 4'b0001, "R4");
        lit16(16'h3C00, 16'h1000, 1'b0, 2'd1, 16'h3C00, 4'b0001, "R10");
        lit16(16'h0400, 16'h0001, 1'b1, 2'd0, 16'h03FF, 4'b0010, "R5");
        lit16(16'h0001, 16'h0001, 1'b0, 2'd0, 16'h0002, 4'b0010, "R5");
        lit16(16'h0200, 16'h0200, 1'b0, 2'd0, 16'h0400, 4'b0000, "R5");
        lit16(16'h7BFF, 16'h7BFF, 1'b0, 2'd0, 16'h7C00, 4'b0101, "R6");
        lit16(16'h7BFF, 16'h7BFF, 1'b0, 2'd1, 16'h7BFF, 4'b0101, "R6");
        lit16(16'h7BFF, 16'h7BFF, 1'b0, 2'd3, 16'h7BFF, 4'b0101, "R6");
        lit16(16'hFBFF, 16'h7BFF, 1'b1, 2'd3, 16'hFC00, 4'b0101, "R6");
        lit16(16'h7C01, 16'h3C00, 1'b0, 2'd0, 16'h7E00, 4'b1000, "R7");
        lit16(16'h3C00, 16'hFE00, 1'b0, 2'd0, 16'h7E00, 4'b0000, "R7");
        lit16(16'h7C00, 16'h7C00, 1'b1, 2'd0, 16'h7E00, 4'b1000, "R8");
        lit16(16'h7C00, 16'hFC00, 1'b1, 2'd0, 16'h7C00, 4'b0000, "R8");
        lit16(16'h3C00, 16'h7C00, 1'b1, 2'd0, 16'hFC00, 4'b0000, "R8");
        lit16(16'h3C00, 16'h3C00, 1'b1, 2'd0, 16'h0000, 4'b0000, "R9");
        lit16(16'h3C00, 16'h3C00, 1'b1, 2'd3, 16'h8000, 4'b0000, "R9");
        lit16(16'h8000, 16'h0000, 1'b1, 2'd0, 16'h8000, 4'b0000, "R9");

        // R11: the cancellation example in the 6-bit format
        a1 = 6'b0_100_00; b1 = 6'b0_011_11; op_sub = 1'b1; rnd = 2'd0;
        @(negedge clk);
        check("R11", {inv1, ovf1, unf1, inx1, 10'd0, r1}, {4'b0000, 10'd0, 6'b0_001_00}, "guard");

        // R11: every operand pair, operation and mode of the 6-bit format
        for (int ia = 0; ia < 64; ia++)
            for (int ib = 0; ib < 64; ib++)
                for (int k = 0; k < 8; k++)
                    do6(6'(ia), 6'(ib), k[2], k[1:0]);

        // Random half-precision operands, half of them built for cancellation
        for (int n = 0; n < 20000; n++) begin
            ra = rand_op();
            if ($urandom % 2 == 0) rb = rand_op();
            else begin
                rb = ra ^ 16'($urandom % 64);
                if ($urandom % 4 == 0) rb[10] = ~rb[10];
                if ($urandom % 2 == 0) rb[15] = ~rb[15];
            end
            do16(ra, rb, 1'($urandom), 2'($urandom), "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule